// File: doc/BRIEF.md
# Register Rename Alias Table

This block keeps the mapping from architectural register indices to physical register indices in an out-of-order core. Any architectural register can be read through a combinational query port, which returns the physical register that currently holds it. A circular free list holds the physical registers that are not in use. An allocation takes the register at the head of that list, points the requested architectural register at it, and records the physical register it replaced.

That record is kept per physical register. It holds the owning architectural index, the displaced predecessor and a pending bit. With it, a flush can undo an allocation and a retirement can finalise one, and each of these needs only the physical index. A rewind puts the predecessor back into the mapping and frees the rewound register. A commit frees the predecessor and clears the record, so that mapping can no longer be rewound. A status output shows when no uncommitted allocation remains. A core with several register classes instantiates one table per class, each with its own parameters.

Only one of rewind, commit and allocate takes effect in a cycle, and rewinds are issued youngest first.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The output `synced` is high and `stall` is low. The free list holds physical registers ARCH_REGS to PHYS_REGS-1 and hands them out in ascending order.
- R2: `q_phys` shows, in the same cycle, the current mapping of `q_arch`.
- R3: When `alloc_req` is high and the request is accepted, `alloc_grant` is high and `alloc_phys` shows the head of the free list in that same cycle. From the next cycle on, `alloc_arch` maps to `alloc_phys`.
- R4: A rewind of a pending physical register maps its architectural register back to the saved predecessor. It also appends the rewound register to the tail of the free list.
- R5: A commit of a pending physical register leaves the mapping unchanged and appends the saved predecessor to the tail of the free list.
- R6: A rewind or commit that names a register that is not pending has no effect. This includes a register that has already been committed.
- R7: `synced` is high exactly when every accepted allocation has since been rewound or committed.
- R8: While the free list is empty, `alloc_req` raises `stall`. No grant is given and the mapping is unchanged.
- R9: Only one operation takes effect per cycle. `rw_req` wins over `cm_req`, and `cm_req` wins over `alloc_req`. A request that loses is dropped, not queued, and `alloc_grant` stays low while `rw_req` or `cm_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_arch | input | AW | Architectural index to translate |
| q_phys | output | PW | Current physical register of `q_arch` |
| alloc_req | input | 1 | Request a new mapping |
| alloc_arch | input | AW | Architectural register to rename |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_phys | output | PW | Physical register handed out |
| stall | output | 1 | Allocation refused because no register is free |
| rw_req | input | 1 | Rewind request |
| rw_phys | input | PW | Physical register to rewind |
| cm_req | input | 1 | Commit request |
| cm_phys | input | PW | Physical register to commit |
| synced | output | 1 | No uncommitted allocation remains |

## Verification
The bench renames one architectural register twice and then rewinds both allocations youngest first. The second allocation is rewound to the first and the first to the reset mapping, which separates a true predecessor chain from a one-level restore. A commit followed by a rewind of the same register shows that committing closes the record. The allocations that follow check the free-list order, including where the committed predecessor and the rewound registers were appended. Requests are then issued together while the list is empty, and a later rewind of the register whose commit lost arbitration shows whether that commit was applied or dropped.

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = (ARCH_REGS > 1) ? $clog2(ARCH_REGS) : 1,
  localparam int PW = $clog2(PHYS_REGS),
  localparam int FREE_N = PHYS_REGS - ARCH_REGS,
  localparam int FW = (FREE_N > 1) ? $clog2(FREE_N) : 1,
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] q_arch,
  output logic [PW-1:0] q_phys,
  input  logic          alloc_req,
  input  logic [AW-1:0] alloc_arch,
  output logic          alloc_grant,
  output logic [PW-1:0] alloc_phys,
  output logic          stall,
  input  logic          rw_req,
  input  logic [PW-1:0] rw_phys,
  input  logic          cm_req,
  input  logic [PW-1:0] cm_phys,
  output logic          synced
);

  logic [PW-1:0] map [ARCH_REGS];
  logic [PW-1:0] fifo [FREE_N];
  logic [AW-1:0] own_arch [PHYS_REGS];
  logic [PW-1:0] prev_phys [PHYS_REGS];
  logic [PHYS_REGS-1:0] pend;
  logic [FW-1:0] head, tail;
  logic [CW-1:0] free_cnt, pend_cnt;

  logic do_rw, do_cm, push;
  logic [PW-1:0] push_val;

  assign q_phys      = map[q_arch];
  assign alloc_phys  = fifo[head];
  assign stall       = alloc_req && (free_cnt == '0);
  assign alloc_grant = alloc_req && !rw_req && !cm_req && (free_cnt != '0);
  assign do_rw       = rw_req && pend[rw_phys];
  assign do_cm       = cm_req && !rw_req && pend[cm_phys];
  assign push        = do_rw || do_cm;
  assign push_val    = do_rw ? rw_phys : prev_phys[cm_phys];
  assign synced      = (pend_cnt == '0);

  function automatic logic [FW-1:0] wrap_inc(input logic [FW-1:0] p);
    return (p == FW'(FREE_N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map[i] <= PW'(i);
      for (int k = 0; k < FREE_N; k++) fifo[k] <= PW'(ARCH_REGS + k);
      for (int p = 0; p < PHYS_REGS; p++) begin
        own_arch[p]  <= '0;
        prev_phys[p] <= '0;
      end
      pend     <= '0;
      head     <= '0;
      tail     <= '0;
      free_cnt <= CW'(FREE_N);
      pend_cnt <= '0;
    end else if (do_rw) begin
      map[own_arch[rw_phys]] <= prev_phys[rw_phys];
      pend[rw_phys] <= 1'b0;
      pend_cnt <= pend_cnt - 1'b1;
    end else if (do_cm) begin
      pend[cm_phys] <= 1'b0;
      pend_cnt <= pend_cnt - 1'b1;
    end else if (alloc_grant) begin
      map[alloc_arch]        <= alloc_phys;
      own_arch[alloc_phys]   <= alloc_arch;
      prev_phys[alloc_phys]  <= map[alloc_arch];
      pend[alloc_phys]       <= 1'b1;
      head     <= wrap_inc(head);
      free_cnt <= free_cnt - 1'b1;
      pend_cnt <= pend_cnt + 1'b1;
    end
    if (rst_n && push) begin
      fifo[tail] <= push_val;
      tail       <= wrap_inc(tail);
      free_cnt   <= free_cnt + 1'b1;
    end
  end

endmodule

module rename_alias_table_chk #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int AW = 3,
  parameter int PW = 4,
  parameter int CW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_grant,
  input logic [AW-1:0]        alloc_arch,
  input logic [PW-1:0]        alloc_phys,
  input logic                 stall,
  input logic                 rw_req,
  input logic [PW-1:0]        rw_phys,
  input logic                 cm_req,
  input logic [PW-1:0]        cm_phys,
  input logic                 synced,
  input logic [PW-1:0]        map [ARCH_REGS],
  input logic [PHYS_REGS-1:0] pend,
  input logic [CW-1:0]        free_cnt
);

  p_alloc_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> map[$past(alloc_arch)] == $past(alloc_phys));

  p_rewind_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req && pend[rw_phys]) |=> (!pend[$past(rw_phys)] && free_cnt == $past(free_cnt) + 1'b1));

  p_commit_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req && !rw_req && pend[cm_phys]) |=> free_cnt == $past(free_cnt) + 1'b1);

  p_sync_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> !synced);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rw_req && !cm_req) |=> free_cnt == '0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(PHYS_REGS - ARCH_REGS));

  p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req || cm_req) |-> !alloc_grant);

endmodule

bind rename_alias_table rename_alias_table_chk #(
  .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .AW(AW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_grant(alloc_grant), .alloc_arch(alloc_arch),
  .alloc_phys(alloc_phys), .stall(stall), .rw_req(rw_req), .rw_phys(rw_phys),
  .cm_req(cm_req), .cm_phys(cm_phys), .synced(synced), .map(map), .pend(pend),
  .free_cnt(free_cnt)
);

// File: tb/tb_rename_alias_table.sv
module tb_rename_alias_table;
  localparam int NA = 4;
  localparam int NP = 8;
  localparam int AW = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] q_arch = '0, alloc_arch = '0;
  logic [PW-1:0] q_phys, alloc_phys, rw_phys = '0, cm_phys = '0;
  logic alloc_req = 1'b0, rw_req = 1'b0, cm_req = 1'b0;
  logic alloc_grant, stall, synced;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rename_alias_table #(.ARCH_REGS(NA), .PHYS_REGS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .q_arch(q_arch), .q_phys(q_phys),
    .alloc_req(alloc_req), .alloc_arch(alloc_arch), .alloc_grant(alloc_grant),
    .alloc_phys(alloc_phys), .stall(stall), .rw_req(rw_req), .rw_phys(rw_phys),
    .cm_req(cm_req), .cm_phys(cm_phys), .synced(synced)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    alloc_req = 1'b0; rw_req = 1'b0; cm_req = 1'b0;
  endtask

  task automatic query(input int a, input int exp, input string tag);
    q_arch = AW'(a);
    #1 chk(tag, int'(q_phys), exp);
  endtask

  task automatic alloc(input int a, input int exp, input string tag);
    alloc_req = 1'b1; alloc_arch = AW'(a);
    #1 chk({tag, " grant"}, int'(alloc_grant), 1);
    chk({tag, " phys"}, int'(alloc_phys), exp);
    cyc();
  endtask

  task automatic rewind(input int p);
    rw_req = 1'b1; rw_phys = PW'(p);
    cyc();
  endtask

  task automatic commit(input int p);
    cm_req = 1'b1; cm_phys = PW'(p);
    cyc();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NA; i++) query(i, i, "R1 identity map");
    chk("R1 synced", int'(synced), 1);
    chk("R1 stall", int'(stall), 0);
    query(2, 2, "R2 query");
  endtask

  task automatic t_alloc_rewind();
    alloc(1, 4, "R1 R3 first alloc");
    query(1, 4, "R3 map updated");
    chk("R7 not synced", int'(synced), 0);
    alloc(1, 5, "R3 second alloc");
    query(1, 5, "R2 query after alloc");
    rewind(5);
    query(1, 4, "R4 rewind youngest");
    rewind(4);
    query(1, 1, "R4 rewind to reset map");
    chk("R7 synced after rewinds", int'(synced), 1);
  endtask

  task automatic t_commit();
    alloc(2, 6, "R4 free order");
    commit(6);
    query(2, 6, "R5 commit keeps map");
    chk("R7 synced after commit", int'(synced), 1);
    rewind(6);
    query(2, 6, "R6 rewind after commit ignored");
    alloc(0, 7, "R6 no push from ignored rewind");
    alloc(0, 5, "R4 rewound reg reused");
    alloc(3, 4, "R4 rewound reg order");
    alloc(3, 2, "R5 committed predecessor freed");
  endtask

  task automatic t_empty();
    alloc_req = 1'b1; alloc_arch = AW'(1);
    #1 chk("R8 stall", int'(stall), 1);
    chk("R8 no grant", int'(alloc_grant), 0);
    cyc();
    query(1, 1, "R8 map unchanged");
    chk("R8 stall drops", int'(stall), 0);
    chk("R7 pending", int'(synced), 0);
  endtask

  task automatic t_priority();
    rw_req = 1'b1; rw_phys = PW'(2);
    cm_req = 1'b1; cm_phys = PW'(4);
    alloc_req = 1'b1; alloc_arch = AW'(1);
    #1 chk("R9 grant blocked", int'(alloc_grant), 0);
    cyc();
    query(3, 4, "R9 rewind won");
    query(1, 1, "R9 alloc dropped");
    rewind(4);
    query(3, 3, "R9 commit was dropped");
    commit(7);
    commit(5);
    chk("R7 synced after commits", int'(synced), 1);
    query(0, 5, "R5 map kept after commits");
    cm_req = 1'b1; cm_phys = PW'(2);
    alloc_req = 1'b1; alloc_arch = AW'(2);
    #1 chk("R9 commit blocks alloc", int'(alloc_grant), 0);
    cyc();
    query(2, 6, "R6 stale commit no effect");
    alloc(1, 2, "R4 R5 tail order");
    rewind(2);
    query(1, 1, "R4 final rewind");
    chk("R7 final synced", int'(synced), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_rewind();
    t_commit();
    t_empty();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule